// File: doc/BRIEF.md
# Acquisition Run Start/Stop Controller

This block decides when an acquisition run is active. Several start sources can be enabled at the same time through a select vector. Level-type sources are the encoded sync input, SIN used as a level, the LVDS run line and the backplane run line. Each of these starts a run on its rising edge and holds the run for as long as it stays high. Latching sources are SIN used as an edge and the software start pulse. Either of these starts a run that only a software stop ends. The four external run lines are asynchronous and pass through synchronizers before edge detection. The software pulses are synchronous to the clock.

A run can only start while the controller is armed, and a software arm pulse arms it. When auto-disarm is enabled, every end of run clears the armed state, so an external line cannot restart acquisition until software rearms the controller. When auto-disarm is disabled, the controller stays armed and each new start transition begins another run.

Two forms of the run signal are produced. The undelayed run is meant for propagation to the next board in a chain. The internal run rises a programmable number of clock cycles after the undelayed run rises, which aligns the start across a daisy chain. For example, with two cycles of link delay per board, the last board uses 0, the board before it uses 2, and so on. A stop applies to both forms in the same cycle.

Top module: `run_sequencer`

## Requirements
- R1: After reset, `run_prop`, `run_out` and `armed` are all 0.
- R2: A one-cycle `sw_arm` pulse sets `armed` at the next clock edge. No run starts while `armed` is 0.
- R3: The level sources are selected by `src_en` bit 0 (sync), bit 1 (SIN level), bit 4 (LVDS) and bit 5 (backplane). A rising edge on any enabled level source starts a run. A run started this way ends once no enabled level source is high.
- R4: SIN-edge mode is selected by `src_en` bit 2. A rising edge on SIN starts a run. A falling edge on SIN does not end that run. Only `sw_stop` ends it.
- R5: Software mode is selected by `src_en` bit 3. A `sw_start` pulse starts a run, and the run stays active until `sw_stop`.
- R6: A `sw_stop` pulse clears `run_prop` at the next clock edge in every mode, even while a level source is still high. The run does not restart without a new start event.
- R7: A source whose `src_en` bit is 0 has no effect on the run.
- R8: When several sources are enabled, any one of them can start a run. A level-held run continues while any enabled level source remains high.
- R9: With `auto_disarm` at 1, the end of a run clears `armed`. Later start events are then ignored until the next `sw_arm`.
- R10: With `auto_disarm` at 0, `armed` stays set after a run ends, and a new start transition begins another run.
- R11: `run_out` rises exactly `run_delay` clock edges after `run_prop` rises. With `run_delay` at 0, the two signals rise in the same cycle.
- R12: `run_out` falls in the same cycle as `run_prop`, with no delay.
- R13: A change on an asynchronous run line reaches `run_prop` at the third clock edge after it is applied. A software pulse reaches `run_prop` at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 6 | Start source enables: bit 0 sync, bit 1 SIN level, bit 2 SIN edge, bit 3 software, bit 4 LVDS, bit 5 backplane |
| sync_in | input | 1 | Encoded sync run line (asynchronous) |
| sin_in | input | 1 | SIN line (asynchronous) |
| lvds_in | input | 1 | LVDS run line (asynchronous) |
| bkp_in | input | 1 | Backplane run line (asynchronous) |
| sw_start | input | 1 | Software start pulse (synchronous) |
| sw_stop | input | 1 | Software stop pulse (synchronous) |
| sw_arm | input | 1 | Software arm pulse (synchronous) |
| auto_disarm | input | 1 | Clear the armed state at each end of run |
| run_delay | input | DLY_W | Start delay of the internal run, in clock cycles |
| run_out | output | 1 | Delayed run, for internal use |
| run_prop | output | 1 | Undelayed run, for propagation |
| armed | output | 1 | Controller is armed |

## Verification
The assertions assume that `sw_start`, `sw_stop` and `sw_arm` are synchronous one-cycle pulses. They also assume that `run_delay` and `auto_disarm` are held steady around every start and stop. The bench changes every input only on the falling clock edge, and it changes configuration only while the controller is idle. The asynchronous lines are held for several cycles at a time, so each change passes cleanly through the synchronizers. The bench never asserts a software pulse in the same cycle as another event it is checking.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Positions in the source enable vector.
  localparam int SRC_N       = 6;
  localparam int SRC_SYNC    = 0;
  localparam int SRC_SINLVL  = 1;
  localparam int SRC_SINEDGE = 2;
  localparam int SRC_SW      = 3;
  localparam int SRC_LVDS    = 4;
  localparam int SRC_BKP     = 5;

  // Positions in the asynchronous line vector.
  localparam int LINE_N    = 4;
  localparam int LINE_SYNC = 0;
  localparam int LINE_SIN  = 1;
  localparam int LINE_LVDS = 2;
  localparam int LINE_BKP  = 3;

  // Number of level-type sources.
  localparam int LVL_N = 4;

  typedef struct packed {
    logic latch_start; // start from a source that holds the run until sw_stop
    logic level_start; // rising edge on an enabled level source
    logic level_hold;  // some enabled level source is currently high
  } start_req_t;
endpackage

// File: rtl/rs_sync_edge.sv
module rs_sync_edge #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  localparam int TOP = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], line_i[i]};
        prev <= sh[TOP];
      end
    end

    assign lvl_o[i]  = sh[TOP];
    assign rise_o[i] = sh[TOP] & ~prev;
  end
endmodule

// File: rtl/rs_src_decode.sv
module rs_src_decode
  import rs_pkg::*;
(
  input  logic [SRC_N-1:0]  src_en,
  input  logic [LINE_N-1:0] lvl,
  input  logic [LINE_N-1:0] rise,
  input  logic              sw_start,
  output start_req_t        req
);
  logic [LVL_N-1:0] lvl_en;
  logic [LVL_N-1:0] lvl_now;
  logic [LVL_N-1:0] lvl_rise;

  always_comb begin
    lvl_en   = {src_en[SRC_BKP], src_en[SRC_LVDS], src_en[SRC_SINLVL], src_en[SRC_SYNC]};
    lvl_now  = {lvl[LINE_BKP], lvl[LINE_LVDS], lvl[LINE_SIN], lvl[LINE_SYNC]};
    lvl_rise = {rise[LINE_BKP], rise[LINE_LVDS], rise[LINE_SIN], rise[LINE_SYNC]};

    req.level_start = |(lvl_en & lvl_rise);
    req.level_hold  = |(lvl_en & lvl_now);
    req.latch_start = (src_en[SRC_SINEDGE] & rise[LINE_SIN]) |
                      (src_en[SRC_SW] & sw_start);
  end
endmodule

// File: rtl/rs_run_fsm.sv
module rs_run_fsm
  import rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  start_req_t req,
  input  logic       sw_stop,
  input  logic       sw_arm,
  input  logic       auto_disarm,
  output logic       run_q,
  output logic       armed_q
);
  logic latch_q;
  logic start_evt, end_evt, run_d, latch_d, armed_d;

  always_comb begin
    start_evt = ~run_q & armed_q & ~sw_stop & (req.latch_start | req.level_start);
    end_evt   = run_q & (sw_stop | (~latch_q & ~req.level_hold & ~req.latch_start));

    if (start_evt)      run_d = 1'b1;
    else if (end_evt)   run_d = 1'b0;
    else                run_d = run_q;

    latch_d = run_d & (latch_q | req.latch_start);

    if (sw_arm)                      armed_d = 1'b1;
    else if (end_evt && auto_disarm) armed_d = 1'b0;
    else                             armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      latch_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      latch_q <= latch_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/rs_start_delay.sv
module rs_start_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             run_o
);
  logic [DLY_W-1:0] cnt;
  logic             reached;

  assign reached = (cnt >= delay_i);
  assign run_o   = run_i & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i)           cnt <= '0;
    else if (!reached)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
  import rs_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       src_en,
  input  logic             sync_in,
  input  logic             sin_in,
  input  logic             lvds_in,
  input  logic             bkp_in,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             sw_arm,
  input  logic             auto_disarm,
  input  logic [DLY_W-1:0] run_delay,
  output logic             run_out,
  output logic             run_prop,
  output logic             armed
);
  logic [LINE_N-1:0] lines, lvl, rise;
  start_req_t        req;
  logic              run_q, armed_q;

  always_comb begin
    lines            = '0;
    lines[LINE_SYNC] = sync_in;
    lines[LINE_SIN]  = sin_in;
    lines[LINE_LVDS] = lvds_in;
    lines[LINE_BKP]  = bkp_in;
  end

  rs_sync_edge #(.N(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .lvl_o(lvl), .rise_o(rise)
  );

  rs_src_decode u_dec (
    .src_en(src_en), .lvl(lvl), .rise(rise), .sw_start(sw_start), .req(req)
  );

  rs_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .sw_stop(sw_stop), .sw_arm(sw_arm),
    .auto_disarm(auto_disarm), .run_q(run_q), .armed_q(armed_q)
  );

  rs_start_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .delay_i(run_delay), .run_o(run_out)
  );

  assign run_prop = run_q;
  assign armed    = armed_q;
endmodule

// File: rtl/run_sequencer_chk.sv
module run_sequencer_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_stop,
  input logic             sw_arm,
  input logic             auto_disarm,
  input logic [DLY_W-1:0] run_delay,
  input logic             run_prop,
  input logic             run_out,
  input logic             armed
);
  // R2: a run only begins while armed
  assert_start_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_prop) |-> $past(armed));

  // R6: software stop always ends the run
  assert_sw_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !run_prop);

  // R9: end of run with auto-disarm clears the armed state
  assert_auto_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_prop) && $past(auto_disarm) && !$past(sw_arm)) |-> !armed);

  // R10: without auto-disarm the armed state survives the end of a run
  assert_keep_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_prop) && !$past(auto_disarm)) |-> armed);

  // R11: zero delay gives no lag
  assert_zero_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prop && run_delay == '0) |-> run_out);

  // R12: the delayed run never outlasts the undelayed one
  assert_out_inside_prop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run_out |-> run_prop);
endmodule

bind run_sequencer run_sequencer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_stop(sw_stop), .sw_arm(sw_arm),
  .auto_disarm(auto_disarm), .run_delay(run_delay), .run_prop(run_prop),
  .run_out(run_out), .armed(armed)
);

// File: tb/tb_run_sequencer.sv
module tb_run_sequencer;
  localparam int DLY_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] src_en = '0;
  logic sync_in = 0, sin_in = 0, lvds_in = 0, bkp_in = 0;
  logic sw_start = 0, sw_stop = 0, sw_arm = 0, auto_disarm = 0;
  logic [DLY_W-1:0] run_delay = '0;
  logic run_out, run_prop, armed;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  run_sequencer #(.DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .sync_in(sync_in), .sin_in(sin_in),
    .lvds_in(lvds_in), .bkp_in(bkp_in), .sw_start(sw_start), .sw_stop(sw_stop),
    .sw_arm(sw_arm), .auto_disarm(auto_disarm), .run_delay(run_delay),
    .run_out(run_out), .run_prop(run_prop), .armed(armed)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_arm();   sw_arm = 1;   step(1); sw_arm = 0;   endtask
  task automatic do_start(); sw_start = 1; step(1); sw_start = 0; endtask
  task automatic do_stop();  sw_stop = 1;  step(1); sw_stop = 0;  endtask

  task automatic t_reset();
    step(2);
    chk("R1", "run_prop in reset", run_prop, 1'b0);
    chk("R1", "run_out in reset", run_out, 1'b0);
    rst_n = 1;
    step(2);
    chk("R1", "armed after reset", armed, 1'b0);
    chk("R1", "run_prop after reset", run_prop, 1'b0);
  endtask

  task automatic t_software();
    src_en = 6'b001000;
    do_start();
    chk("R2", "no run while disarmed", run_prop, 1'b0);
    do_arm();
    chk("R2", "armed after pulse", armed, 1'b1);
    do_start();
    chk("R13", "sw start after one edge", run_prop, 1'b1);
    step(6);
    chk("R5", "software run holds", run_prop, 1'b1);
    do_stop();
    chk("R6", "sw stop ends run", run_prop, 1'b0);
  endtask

  task automatic t_sync_level();
    src_en = 6'b000001;
    sync_in = 1;
    step(2);
    chk("R13", "sync not yet through", run_prop, 1'b0);
    step(1);
    chk("R3", "sync rise starts run", run_prop, 1'b1);
    step(3);
    sync_in = 0;
    step(2);
    chk("R13", "sync fall not yet through", run_prop, 1'b1);
    step(1);
    chk("R3", "sync fall ends run", run_prop, 1'b0);
    chk("R10", "still armed", armed, 1'b1);
    sync_in = 1;
    step(3);
    chk("R10", "second sync run", run_prop, 1'b1);
    sync_in = 0;
    step(4);
  endtask

  task automatic t_sin_level();
    src_en = 6'b000010;
    sin_in = 1;
    step(3);
    chk("R3", "SIN level starts", run_prop, 1'b1);
    sin_in = 0;
    step(3);
    chk("R3", "SIN level low stops", run_prop, 1'b0);
  endtask

  task automatic t_sin_edge();
    src_en = 6'b000100;
    sin_in = 1;
    step(3);
    chk("R4", "SIN edge starts", run_prop, 1'b1);
    sin_in = 0;
    step(6);
    chk("R4", "SIN fall keeps run", run_prop, 1'b1);
    do_stop();
    chk("R4", "sw stop ends edge run", run_prop, 1'b0);
  endtask

  task automatic t_disabled();
    src_en = 6'b001000;
    sync_in = 1; sin_in = 1; lvds_in = 1; bkp_in = 1;
    step(6);
    chk("R7", "disabled lines ignored", run_prop, 1'b0);
    sync_in = 0; sin_in = 0; lvds_in = 0; bkp_in = 0;
    step(4);
  endtask

  task automatic t_multi();
    src_en = 6'b110000;
    bkp_in = 1;
    step(3);
    chk("R8", "backplane starts", run_prop, 1'b1);
    lvds_in = 1;
    step(3);
    bkp_in = 0;
    step(5);
    chk("R8", "held by LVDS", run_prop, 1'b1);
    lvds_in = 0;
    step(3);
    chk("R8", "all low ends run", run_prop, 1'b0);
  endtask

  task automatic t_stop_over_level();
    src_en = 6'b000001;
    sync_in = 1;
    step(3);
    chk("R6", "level run up", run_prop, 1'b1);
    do_stop();
    chk("R6", "stop over high level", run_prop, 1'b0);
    step(5);
    chk("R6", "no restart while level high", run_prop, 1'b0);
    sync_in = 0;
    step(4);
  endtask

  task automatic t_auto_disarm();
    auto_disarm = 1;
    src_en = 6'b000001;
    sync_in = 1;
    step(3);
    chk("R9", "run with auto-disarm", run_prop, 1'b1);
    sync_in = 0;
    step(3);
    chk("R9", "disarmed at end", armed, 1'b0);
    sync_in = 1;
    step(5);
    chk("R9", "start ignored while disarmed", run_prop, 1'b0);
    sync_in = 0;
    step(4);
    do_arm();
    sync_in = 1;
    step(3);
    chk("R9", "rearmed start", run_prop, 1'b1);
    sync_in = 0;
    step(4);
    auto_disarm = 0;
    do_arm();
  endtask

  task automatic t_delay();
    src_en = 6'b001000;
    run_delay = 4;
    do_start();
    chk("R11", "prop up", run_prop, 1'b1);
    chk("R11", "out still low", run_out, 1'b0);
    step(3);
    chk("R11", "out low at edge 3", run_out, 1'b0);
    step(1);
    chk("R11", "out high at edge 4", run_out, 1'b1);
    do_stop();
    chk("R12", "out drops with stop", run_out, 1'b0);
    run_delay = 0;
    do_start();
    chk("R11", "zero delay", run_out, 1'b1);
    do_stop();
    run_delay = 2;
    src_en = 6'b000001;
    sync_in = 1;
    step(6);
    chk("R11", "delayed level run", run_out, 1'b1);
    sync_in = 0;
    step(3);
    chk("R12", "out drops with level end", run_out, 1'b0);
    run_delay = 0;
  endtask

  initial begin
    t_reset();
    t_software();
    t_sync_level();
    t_sin_level();
    t_sin_edge();
    t_disabled();
    t_multi();
    t_stop_over_level();
    t_auto_disarm();
    t_delay();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule